// File: doc/BRIEF.md
# Low-Pulse Buffered PWM Generator

A single-channel pulse-width modulator driven by one input clock and set up through a small synchronous 32-bit register port. Software does not program a duty cycle. It programs a period length and the length of the low phase, both counted in clock cycles. In each period the output is high for the first (period − low) cycles and low for the remaining low cycles.

The period and low-phase registers are buffers. The counter works from its own working copies, which take new buffer values only when a new period begins. This keeps every period glitch-free while software rewrites the buffers. Clearing the enable freezes the counter where it stands. Setting it again resumes the interrupted period with its old settings. To apply new settings at once, software sets the counter-reset bit, which holds the counter at zero. It then clears that bit and sets enable in the same write, so the first cycle of the new period already uses the current buffers. An inversion bit flips the output polarity. An active-low enable bit for the output driver is brought out on its own pin.

Top module: `lowpulse_pwm`

## Requirements
- R1: After reset every register reads 0, the counter is 0, `pwm_out` is 0 and `pwm_oe_n` is 0.
- R2: The low-phase buffer sits at byte offset 0x4 and the period buffer at 0x8. Both are 32-bit and read back the last value written. The control register sits at 0xC and keeps only bit 0 (enable), bit 3 (driver disable, active low), bit 7 (counter reset) and bit 9 (invert). All other control bits, and unmapped offsets, read 0.
- R3: Offset 0x0 reads the current counter value. Writes to offset 0x0 have no effect.
- R4: While running (enable 1 and reset 0), with period P > 0 and low length L < P, the counter counts 0..P−1 and wraps. The output is high while the counter is below P−L and low otherwise.
- R5: If L ≥ P, the output stays low for the whole period.
- R6: If P is 0 while running, the counter stays at 0 and the output stays low.
- R7: Buffer values are copied into the working registers only in a cycle where the counter is 0 and running. That cycle already uses the buffer values. A buffer write in the middle of a period does not change the period in progress.
- R8: With enable 0 and reset 0 the counter holds its value. Setting enable again resumes from that value and completes the period with its old working values.
- R9: While the reset bit is 1 the counter is forced to 0. Writing enable 1 with reset 0 then starts a new period that uses the current buffers from its first cycle.
- R10: Bit 9 inverts `pwm_out`. When not running, `pwm_out` sits at its inactive level: 0, or 1 when inverted.
- R11: `pwm_oe_n` follows control bit 3 (1 disables the output driver).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_addr | input | 4 | Byte offset of the register accessed |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pwm_out | output | 1 | PWM waveform after polarity |
| pwm_oe_n | output | 1 | Active-low enable for the output driver |

## Verification
The bench aims at a counter frozen mid-period while new buffers are written. A design that loads the buffers on re-enable, or clears the counter when it stops, would produce a period of the wrong length there. It also rewrites the buffers in the middle of a period, where an unbuffered design would bend the running period. It releases the reset bit together with enable, where a design that loads one cycle late would emit one cycle of stale settings. Period 0, low lengths equal to or larger than the period, and inversion while idle are each driven directly. A mistake in clamping the high time, or in the idle level, shows up as a wrong output level in those cycles.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_COUNT = 32'h0;
  localparam int unsigned OFS_LOW   = 32'h4;
  localparam int unsigned OFS_PER   = 32'h8;
  localparam int unsigned OFS_CTL   = 32'hC;

  // Control bit positions
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_OEN   = 3;
  localparam int unsigned CTL_RST   = 7;
  localparam int unsigned CTL_INV   = 9;

  typedef struct packed {
    logic inv;
    logic rst;
    logic oe_n;
    logic en;
  } ctl_t;

endpackage

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_view,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] low_buf,
  output logic [DATA_W-1:0] per_buf,
  output ctl_t              ctl
);

  function automatic logic hits(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctl(input ctl_t c);
    logic [DATA_W-1:0] v;
    v          = '0;
    v[CTL_EN]  = c.en;
    v[CTL_OEN] = c.oe_n;
    v[CTL_RST] = c.rst;
    v[CTL_INV] = c.inv;
    return v;
  endfunction

  logic wr_low, wr_per, wr_ctl;
  assign wr_low = wr && hits(addr, OFS_LOW);
  assign wr_per = wr && hits(addr, OFS_PER);
  assign wr_ctl = wr && hits(addr, OFS_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_buf <= '0;
      per_buf <= '0;
      ctl     <= '0;
    end else begin
      if (wr_low) low_buf <= wdata;
      if (wr_per) per_buf <= wdata;
      if (wr_ctl) begin
        ctl.en   <= wdata[CTL_EN];
        ctl.oe_n <= wdata[CTL_OEN];
        ctl.rst  <= wdata[CTL_RST];
        ctl.inv  <= wdata[CTL_INV];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hits(addr, OFS_COUNT)) rdata = count_view;
    if (hits(addr, OFS_LOW))   rdata = low_buf;
    if (hits(addr, OFS_PER))   rdata = per_buf;
    if (hits(addr, OFS_CTL))   rdata = pack_ctl(ctl);
  end

endmodule

// File: rtl/lpwm_counter.sv
module lpwm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             hold_zero,
  input  logic [CNT_W-1:0] low_buf,
  input  logic [CNT_W-1:0] per_buf,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] low_act,
  output logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] low_eff,
  output logic [CNT_W-1:0] per_eff,
  output logic             run,
  output logic             period_start
);

  // True when the count has reached the last cycle of the period
  function automatic logic at_wrap(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] p);
    return (p == '0) || (c >= p - CNT_W'(1));
  endfunction

  logic at_zero;
  assign at_zero      = (cnt == '0);
  assign run          = en && !hold_zero;
  assign period_start = run && at_zero;

  // At count zero the buffers are used directly, so the first cycle of a
  // period already runs on the freshly loaded settings.
  assign low_eff = at_zero ? low_buf : low_act;
  assign per_eff = at_zero ? per_buf : per_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      low_act <= '0;
      per_act <= '0;
    end else begin
      if (period_start) begin
        low_act <= low_buf;
        per_act <= per_buf;
      end
      if (hold_zero) begin
        cnt <= '0;
      end else if (en) begin
        if (at_wrap(cnt, per_eff)) cnt <= '0;
        else                       cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/lpwm_wave.sv
module lpwm_wave #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             run,
  input  logic             inv,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] low_eff,
  input  logic [CNT_W-1:0] per_eff,
  output logic             level,
  output logic             pwm
);

  // Number of high cycles at the start of a period, clamped at zero
  function automatic logic [CNT_W-1:0] high_time(input logic [CNT_W-1:0] p,
                                                 input logic [CNT_W-1:0] l);
    return (p > l) ? (p - l) : '0;
  endfunction

  assign level = run && (cnt < high_time(per_eff, low_eff));
  assign pwm   = level ^ inv;

endmodule

// File: rtl/lowpulse_pwm.sv
module lowpulse_pwm
  import lpwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pwm_out,
  output logic              pwm_oe_n
);

  localparam int unsigned CNT_W = DATA_W;

  ctl_t             ctl;
  logic [CNT_W-1:0] low_buf, per_buf;
  logic [CNT_W-1:0] cnt, low_act, per_act, low_eff, per_eff;
  logic             run, period_start, level;
  logic             en_bit, rst_bit, inv_bit;

  assign en_bit  = ctl.en;
  assign rst_bit = ctl.rst;
  assign inv_bit = ctl.inv;

  lpwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .count_view (cnt),
    .rdata      (reg_rdata),
    .low_buf    (low_buf),
    .per_buf    (per_buf),
    .ctl        (ctl)
  );

  lpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en_bit),
    .hold_zero    (rst_bit),
    .low_buf      (low_buf),
    .per_buf      (per_buf),
    .cnt          (cnt),
    .low_act      (low_act),
    .per_act      (per_act),
    .low_eff      (low_eff),
    .per_eff      (per_eff),
    .run          (run),
    .period_start (period_start)
  );

  lpwm_wave #(.CNT_W(CNT_W)) u_wave (
    .run     (run),
    .inv     (inv_bit),
    .cnt     (cnt),
    .low_eff (low_eff),
    .per_eff (per_eff),
    .level   (level),
    .pwm     (pwm_out)
  );

  assign pwm_oe_n = ctl.oe_n;

endmodule

// File: rtl/lpwm_checker.sv
module lpwm_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         en_bit,
  input logic         rst_bit,
  input logic         inv_bit,
  input logic         pwm_out,
  input logic [W-1:0] cnt,
  input logic [W-1:0] low_act,
  input logic [W-1:0] per_act,
  input logic [W-1:0] low_eff,
  input logic [W-1:0] per_eff
);

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_eff != '0) |=> (cnt < $past(per_eff)));

  a_r5_low_covers_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && low_eff >= per_eff) |-> (pwm_out == inv_bit));

  a_r6_zero_period_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_eff == '0) |=> (cnt == '0));

  a_r7_working_copy_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_eff != '0 && cnt < per_eff - W'(1))
      |=> (per_act == $past(per_eff) && low_act == $past(low_eff)));

  a_r8_frozen_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_bit && !rst_bit) |=> (cnt == $past(cnt)));

  a_r9_reset_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |=> (cnt == '0));

  a_r10_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pwm_out == inv_bit));

endmodule

bind lowpulse_pwm lpwm_checker #(.W(DATA_W)) u_lpwm_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .en_bit  (en_bit),
  .rst_bit (rst_bit),
  .inv_bit (inv_bit),
  .pwm_out (pwm_out),
  .cnt     (cnt),
  .low_act (low_act),
  .per_act (per_act),
  .low_eff (low_eff),
  .per_eff (per_eff)
);

// File: tb/test_lowpulse_pwm.sv
`timescale 1ns/1ps
module test_lowpulse_pwm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pwm_out, pwm_oe_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  lowpulse_pwm i_lowpulse_pwm (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pwm_out(pwm_out), .pwm_oe_n(pwm_oe_n)
  );

  // Reference state, advanced from the requirement text
  logic [31:0] m_cnt, m_lb, m_pb, m_la, m_pa, m_ctl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lb = 0; m_pb = 0; m_la = 0; m_pa = 0; m_ctl = 0;
    end else begin
      if (m_ctl[7]) m_cnt = 0;                      // R9
      else if (m_ctl[0]) begin
        if (m_cnt == 0) begin m_la = m_lb; m_pa = m_pb; end  // R7
        if (m_pa == 0 || m_cnt == m_pa - 1) m_cnt = 0;       // R4 R6
        else m_cnt = m_cnt + 1;
      end                                           // else hold: R8
      if (reg_wr) begin
        case (reg_addr)
          4'h4: m_lb = reg_wdata;
          4'h8: m_pb = reg_wdata;
          4'hC: m_ctl = reg_wdata & 32'h0000_0289;
          default: ;
        endcase
      end
    end
  end

  function automatic logic exp_pwm();
    logic [31:0] p, l, hi;
    logic run;
    run = m_ctl[0] && !m_ctl[7];
    if (!run) return m_ctl[9];                      // R10
    p  = (m_cnt == 0) ? m_pb : m_pa;
    l  = (m_cnt == 0) ? m_lb : m_la;
    hi = (p > l) ? p - l : 0;                       // R5
    return (m_cnt < hi) ^ m_ctl[9];
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_cnt;
      4'h4: return m_lb;
      4'h8: return m_pb;
      4'hC: return m_ctl;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Every cycle: waveform and driver enable against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({tag, " pwm_out"}, {31'b0, pwm_out}, {31'b0, exp_pwm()});
      check("R11 pwm_oe_n", {31'b0, pwm_oe_n}, {31'b0, m_ctl[3]});
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    reg_wr = 1'b0; reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp_read(a));
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'h1A2B3C4D);
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1: reset state
    check("R1 count", reg_rdata, 32'h0);
    check("R1 pwm_out", {31'b0, pwm_out}, 32'h0);
    check("R1 oe_n", {31'b0, pwm_oe_n}, 32'h0);
    rd("R1 low", 4'h4); rd("R1 per", 4'h8); rd("R1 ctl", 4'hC);

    // R2: read-back and bit mask
    tag = "R2";
    wr(4'h4, 32'hA5A5_5A5A); rd("R2 low", 4'h4);
    wr(4'h8, 32'h1234_5678); rd("R2 per", 4'h8);
    wr(4'hC, 32'hFFFF_FFFF); rd("R2 ctl", 4'hC);
    check("R2 ctl mask", reg_rdata, 32'h0000_0289);
    rd("R2 unmapped", 4'h2);
    wr(4'hC, 32'h0);
    check("R11 oe bit after clear", {31'b0, pwm_oe_n}, 32'h0);

    // R4: basic waveform P=10 L=3
    tag = "R4";
    wr(4'h8, 10); wr(4'h4, 3);
    wr(4'hC, 32'h1);
    tick(25);

    // R7: mid-period writes do not bend the running period
    tag = "R7";
    tick(2);
    wr(4'h8, 6); wr(4'h4, 1);
    tick(20);

    // R8: freeze mid-period, change buffers, resume
    tag = "R8";
    tick(2);
    wr(4'hC, 32'h0);
    wr(4'h8, 14); wr(4'h4, 9);
    tick(4);
    rd("R8 frozen count", 4'h0);
    wr(4'h0, 32'hDEAD_BEEF);                         // R3: ignored
    rd("R3 count after write", 4'h0);
    wr(4'hC, 32'h1);
    tick(30);

    // R9: hold in reset, load new values, release with enable
    tag = "R9";
    tick(3);
    wr(4'hC, 32'h80);
    rd("R9 held count", 4'h0);
    wr(4'h8, 5); wr(4'h4, 2);
    tick(3);
    wr(4'hC, 32'h1);
    tick(15);

    // R5: low length equal to and above period
    tag = "R5";
    wr(4'h4, 5); wr(4'hC, 32'h80); wr(4'hC, 32'h1);
    tick(12);
    wr(4'h4, 40); tick(12);

    // R6: zero period
    tag = "R6";
    wr(4'h8, 0); wr(4'hC, 32'h80); wr(4'hC, 32'h1);
    tick(6);
    rd("R6 count stays zero", 4'h0);

    // R10: inversion while running and idle
    tag = "R10";
    wr(4'h8, 8); wr(4'h4, 3); wr(4'hC, 32'h281); wr(4'hC, 32'h201);
    tick(20);
    wr(4'hC, 32'h200); tick(4);
    wr(4'hC, 32'h288); tick(4);
    check("R11 oe_n set", {31'b0, pwm_oe_n}, 32'h1);

    // Random mix
    tag = "R4 random";
    for (int it = 0; it < 1500; it++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: wr(4'h4, $urandom_range(0, 24));
        2, 3: wr(4'h8, $urandom_range(0, 20));
        4: begin
          logic [31:0] c;
          c = 0;
          c[0] = ($urandom_range(0, 9) < 8);
          c[3] = $urandom_range(0, 1);
          c[7] = ($urandom_range(0, 9) == 0);
          c[9] = $urandom_range(0, 1);
          c[20] = $urandom_range(0, 1);
          wr(4'hC, c);
        end
        5: begin
          logic [3:0] a;
          a = 4'($urandom_range(0, 3) * 4);
          rd("R2 R3 random read", a);
        end
        6: wr(4'h0, $urandom);
        default: tick($urandom_range(1, 12));
      endcase
    end

    tick(2);
    finish_run();
  end

endmodule